// File: doc/BRIEF.md
# SDA Line Conditioner

This stage sits between an I2C byte engine and the SDA pad cell. On the way out, it holds back changes of the SDA drive request for a programmable number of system clocks after every falling edge of SCL. This guarantees data hold time on the bus. On the way in, it can pass the raw SDA pad level through a majority-free agreement filter, so that short glitches never reach the engine's sampler.

A 3-bit line-control value configures both functions, and a single-cycle write strobe loads it. Bits [1:0] give the hold-off in coarse steps of five system clocks, with a top setting of 3 (fifteen clocks). Bit 2 switches the input filter on. SCL is only observed here; the block never drives or filters it.

Top module: `sda_line_cond`

## Requirements
- R1: Synchronous reset (active high) clears the line-control value to 0, sets `sda_drv_out` to 0 (released) and sets `sda_smp_out` to 1 (idle high); after reset, a drive change right after an SCL fall appears with no extra delay.
- R2: When `lc_we` is 1 at a clock edge, `lc_wdata` is stored: bits [1:0] are the delay step count d, and bit 2 enables the input filter; without `lc_we` the stored value does not change.
- R3: With d = 0, `sda_drv_out` takes the value of `sda_drv_req` at the next clock edge, including the edge that samples an SCL fall.
- R4: With d > 0, when an SCL fall is sampled at edge k (`scl_in` was 1 at edge k-1 and is 0 at edge k), `sda_drv_out` keeps its value through edge k+5d-1 and takes `sda_drv_req` again from edge k+5d.
- R5: The largest setting, d = 3, gives a hold-off of exactly 15 clocks, for any value of bit 2.
- R6: With d > 0 but no SCL fall in the last 5d clocks, a drive-request change passes at the next clock edge.
- R7: With the filter off, `sda_smp_out` takes the value of `sda_pad_in` at the next clock edge, so a one-clock pulse passes.
- R8: With the filter on, `sda_smp_out` changes only at an edge where `sda_pad_in` has been at the new level at that edge and the two edges before it; pulses of one or two clocks are rejected.
- R9: An SCL fall sampled while a hold-off count is still running restarts the full 5d-clock count from that fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lc_we | input | 1 | Line-control write strobe |
| lc_wdata | input | 3 | Line-control value: [1:0] delay steps, [2] filter enable |
| sda_drv_req | input | 1 | Drive request from the byte engine (1 = pull SDA low) |
| scl_in | input | 1 | Current SCL line level |
| sda_pad_in | input | 1 | Raw SDA level from the pad |
| sda_drv_out | output | 1 | Delayed SDA drive to the pad (1 = pull low) |
| sda_smp_out | output | 1 | Conditioned SDA sample to the byte engine |

## Verification
The drive path is exercised by lowering SCL and toggling the request on the same clock, for every delay setting with the filter bit both set and clear. The measured latency (1, 6, 11 or 16 clocks to observation) separates the zero-delay pass-through from each step count and shows that the filter bit does not affect the delay. A request change made with SCL steady separates a count that is armed only by an edge from one that runs permanently. A second SCL fall injected mid-count shows that the count restarts rather than continues. On the sample path, pad pulses of one, two and three clocks, with the filter both on and off, separate rejection from pass-through and fix the exact filter latency in both directions.

// File: rtl/sda_lc_pkg.sv
package sda_lc_pkg;

    // Width of the delay-step field inside the line-control value.
    localparam int unsigned DLY_W = 2;
    // Full line-control width: delay field plus the filter enable bit.
    localparam int unsigned LC_W  = DLY_W + 1;

    typedef struct packed {
        logic             flt_en;
        logic [DLY_W-1:0] dly;
    } lc_cfg_t;

    // Number of system clocks a delay-step value stands for.
    function automatic int unsigned dly_ticks(input logic [DLY_W-1:0] d,
                                              input int unsigned      step);
        return 32'(d) * step;
    endfunction

endpackage

// File: rtl/sda_lc_cfg.sv
module sda_lc_cfg
    import sda_lc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [LC_W-1:0] wdata,
    output lc_cfg_t         cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            cfg <= lc_cfg_t'(wdata);
        end
    end

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cfg))
        else $error("line-control value changed without a write");

endmodule

// File: rtl/sda_out_delay.sv
module sda_out_delay
    import sda_lc_pkg::*;
#(
    parameter int unsigned STEP = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DLY_W-1:0] dly,
    input  logic             req,
    input  logic             scl,
    output logic             drv_out
);

    localparam int unsigned MAXT  = STEP * ((1 << DLY_W) - 1);
    localparam int unsigned CNT_W = (MAXT > 2) ? $clog2(MAXT) : 1;

    logic             scl_q;
    logic             fall;
    logic             hold;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_v;

    assign fall   = scl_q & ~scl;
    // The fall edge itself is the first held edge, so load one less.
    assign load_v = (dly == '0) ? '0 : CNT_W'(dly_ticks(dly, STEP) - 1);
    assign hold   = (fall && (dly != '0)) || (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q   <= 1'b1;
            cnt     <= '0;
            drv_out <= 1'b0;
        end else begin
            scl_q <= scl;
            if (fall) begin
                cnt <= load_v;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (!hold) begin
                drv_out <= req;
            end
        end
    end

    // R4
    fall_freezes_chk: assert property (@(posedge clk) disable iff (rst)
        (fall && (dly != '0)) |=> $stable(drv_out))
        else $error("drive changed on a delayed SCL fall");

    // R4
    hold_while_counting_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> $stable(drv_out))
        else $error("drive changed while hold-off counting");

    // R3
    zero_delay_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ((dly == '0) && (cnt == '0)) |=> (drv_out == $past(req)))
        else $error("zero-delay drive did not follow request");

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(MAXT - 1))
        else $error("hold-off counter above largest setting");

endmodule

// File: rtl/sda_in_filter.sv
module sda_in_filter #(
    parameter int unsigned FLT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic pad,
    output logic smp
);

    localparam int unsigned HW = (FLT_LEN > 1) ? FLT_LEN - 1 : 1;

    logic [HW-1:0] hist;
    logic [HW:0]   win;

    assign win = {hist, pad};

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '1;
            smp  <= 1'b1;
        end else begin
            hist <= win[HW-1:0];
            if (!en) begin
                smp <= pad;
            end else if (&win) begin
                smp <= 1'b1;
            end else if (~|win) begin
                smp <= 1'b0;
            end
        end
    end

    // R8
    flt_agree_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && (smp != $past(smp))) |-> (hist == {HW{smp}}))
        else $error("filtered sample moved without agreeing history");

    // R7
    raw_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (smp == $past(pad)))
        else $error("unfiltered sample did not follow pad");

endmodule

// File: rtl/sda_line_cond.sv
module sda_line_cond
    import sda_lc_pkg::*;
#(
    parameter int unsigned STEP    = 5,
    parameter int unsigned FLT_LEN = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lc_we,
    input  logic [LC_W-1:0] lc_wdata,
    input  logic            sda_drv_req,
    input  logic            scl_in,
    input  logic            sda_pad_in,
    output logic            sda_drv_out,
    output logic            sda_smp_out
);

    lc_cfg_t cfg;

    sda_lc_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (lc_we),
        .wdata (lc_wdata),
        .cfg   (cfg)
    );

    sda_out_delay #(.STEP(STEP)) u_dly (
        .clk     (clk),
        .rst     (rst),
        .dly     (cfg.dly),
        .req     (sda_drv_req),
        .scl     (scl_in),
        .drv_out (sda_drv_out)
    );

    sda_in_filter #(.FLT_LEN(FLT_LEN)) u_flt (
        .clk (clk),
        .rst (rst),
        .en  (cfg.flt_en),
        .pad (sda_pad_in),
        .smp (sda_smp_out)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!sda_drv_out && sda_smp_out))
        else $error("outputs not at reset state");

endmodule

// File: tb/sim_sda_line_cond.sv
module sim_sda_line_cond;

    logic       clk = 1'b0;
    logic       rst;
    logic       lc_we;
    logic [2:0] lc_wdata;
    logic       sda_drv_req;
    logic       scl_in;
    logic       sda_pad_in;
    logic       sda_drv_out;
    logic       sda_smp_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    sda_line_cond u0 (
        .clk         (clk),
        .rst         (rst),
        .lc_we       (lc_we),
        .lc_wdata    (lc_wdata),
        .sda_drv_req (sda_drv_req),
        .scl_in      (scl_in),
        .sda_pad_in  (sda_pad_in),
        .sda_drv_out (sda_drv_out),
        .sda_smp_out (sda_smp_out)
    );

    // Vector table: line-control value and the negedge count, from the
    // negedge that lowers SCL and flips the request, to the one where the
    // new drive is seen (5*d + 1).
    localparam int NV = 8;
    localparam logic [2:0] V_CFG [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd7, 3'd5, 3'd4, 3'd6};
    localparam int         V_EXP [NV] = '{1, 6, 11, 16, 16, 6, 1, 11};

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] v);
        @(negedge clk);
        lc_we    = 1'b1;
        lc_wdata = v;
        @(negedge clk);
        lc_we    = 1'b0;
    endtask

    // Called at a negedge with SCL high for a while and request == drive.
    task automatic fall_measure(output int n);
        logic tgt;
        scl_in      = 1'b0;
        sda_drv_req = ~sda_drv_req;
        tgt         = sda_drv_req;
        n           = 0;
        do begin
            @(negedge clk);
            n++;
        end while ((sda_drv_out != tgt) && (n < 40));
        scl_in = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic smp_measure(input logic lvl, output int n);
        sda_pad_in = lvl;
        n          = 0;
        do begin
            @(negedge clk);
            n++;
        end while ((sda_smp_out != lvl) && (n < 40));
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int  n;
        bit  seen_low;
        logic tgt;
        rst         = 1'b1;
        lc_we       = 1'b0;
        lc_wdata    = '0;
        sda_drv_req = 1'b0;
        scl_in      = 1'b1;
        sda_pad_in  = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 drive released", int'(sda_drv_out), 0);
        chk("R1 sample idle high", int'(sda_smp_out), 1);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1: cleared register means no hold-off
        fall_measure(n);
        chk("R1 delay after reset", n, 1);

        // Table walk: R2 field decode, R3/R4/R5 latency
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = (V_EXP[i] == 1) ? "R3" : ((V_EXP[i] == 16) ? "R5" : "R4");
            wr(V_CFG[i]);
            repeat (3) @(negedge clk);
            fall_measure(n);
            chk(tag, n, V_EXP[i]);
        end

        // R6: no SCL fall -> next-clock pass-through even at max setting
        wr(3'd3);
        repeat (20) @(negedge clk);
        sda_drv_req = ~sda_drv_req;
        @(negedge clk);
        chk("R6 no-fall pass", int'(sda_drv_out), int'(sda_drv_req));
        repeat (3) @(negedge clk);

        // R9: second fall mid-count restarts the count
        wr(3'd1);
        repeat (20) @(negedge clk);
        scl_in      = 1'b0;
        sda_drv_req = ~sda_drv_req;
        tgt         = sda_drv_req;
        n           = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 3) scl_in = 1'b1;
            if (n == 4) scl_in = 1'b0;
        end while ((sda_drv_out != tgt) && (n < 40));
        chk("R9 restart", n, 10);
        scl_in = 1'b1;
        repeat (20) @(negedge clk);

        // R8: filter on, delay 0
        wr(3'd4);
        repeat (5) @(negedge clk);
        // one-clock glitch
        seen_low   = 0;
        sda_pad_in = 1'b0;
        @(negedge clk);
        sda_pad_in = 1'b1;
        for (int k = 0; k < 6; k++) begin
            if (!sda_smp_out) seen_low = 1;
            @(negedge clk);
        end
        chk("R8 one-clock glitch rejected", int'(seen_low), 0);
        // two-clock glitch
        seen_low   = 0;
        sda_pad_in = 1'b0;
        @(negedge clk);
        if (!sda_smp_out) seen_low = 1;
        @(negedge clk);
        sda_pad_in = 1'b1;
        for (int k = 0; k < 6; k++) begin
            if (!sda_smp_out) seen_low = 1;
            @(negedge clk);
        end
        chk("R8 two-clock glitch rejected", int'(seen_low), 0);
        smp_measure(1'b0, n);
        chk("R8 filtered fall latency", n, 3);
        smp_measure(1'b1, n);
        chk("R8 filtered rise latency", n, 3);

        // R7: filter off
        wr(3'd0);
        repeat (3) @(negedge clk);
        smp_measure(1'b0, n);
        chk("R7 raw fall latency", n, 1);
        sda_pad_in = 1'b1;
        @(negedge clk);
        sda_pad_in = 1'b0;
        chk("R7 one-clock pulse passes", int'(sda_smp_out), 1);
        @(negedge clk);
        chk("R7 pulse ends", int'(sda_smp_out), 0);
        sda_pad_in = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset in operation clears a nonzero setting
        wr(3'd7);
        sda_drv_req = 1'b1;
        repeat (20) @(negedge clk);
        rst         = 1'b1;
        sda_drv_req = 1'b0;
        sda_pad_in  = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 drive released in reset", int'(sda_drv_out), 0);
        chk("R1 sample high in reset", int'(sda_smp_out), 1);
        rst        = 1'b0;
        sda_pad_in = 1'b1;
        repeat (3) @(negedge clk);
        fall_measure(n);
        chk("R1 setting cleared by reset", n, 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule